// File: doc/BRIEF.md
# Three-Wire Serial Master with Select Guard Timing

This block is a synchronous serial master for a three-wire link. A one-cycle start request carries the number of bits to move, the output word and a bit-rate setting. The block then drives an active-low select, waits a fixed lead interval, and produces a serial clock. On each rising edge it presents one output bit, and it captures one input bit a rate-dependent delay after that edge. After the last clock transition it waits a trailing guard interval, releases the select, pulses `done` and presents the captured word.

All timing is counted in system-clock cycles. The defaults assume a 10 MHz reference, so one cycle is 0.1 µs. The clock-low phase has the same length at every rate. Only the clock-high phase and the input sampling delay depend on the rate setting. Output data changes on the falling clock edge, so the line has settled for a full low phase before the next rising edge. Every interval is a parameter, so a bench can run the same logic with short timings.

Top module: `serial_cs_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `busy` is 0, `done` is 0 and `rx_word` is 0.
- R2: `sclk` stays 0 whenever `cs_n` is 1. The first rising edge of `sclk` comes exactly T_LEAD cycles after `cs_n` falls (default 912).
- R3: Each high phase of `sclk` lasts T_HIGH_FAST, T_HIGH_MID or T_HIGH_SLOW cycles (defaults 258, 678, 9750). The rate is selected by `rate_sel` = 0, 1, or 2/3, and it is latched at start.
- R4: Between two bits, `sclk` stays low for exactly T_LOW cycles (default 330), whatever the rate.
- R5: `cs_n` returns to 1 exactly T_TRAIL cycles after the last falling edge of `sclk` (default 816).
- R6: `mosi` carries the latched output word, most significant of the active bits first, so bit n-1 goes at the first rising edge. `mosi` has not changed for at least T_SETUP cycles (default 54) when `sclk` rises.
- R7: `miso` is captured T_SAMP_FAST, T_SAMP_MID or T_SAMP_SLOW cycles after each rising edge (defaults 114, 534, 9606), depending on the rate. The first captured bit ends up in bit n-1 of `rx_word`, the last in bit 0, and bits n and above read 0.
- R8: The number of rising edges per transfer equals `bit_count`. A value of 0 is treated as 1, and values above 16 are treated as 16.
- R9: A start request while `busy` is 1, including the cycle in which `done` is 1, is ignored. It does not change the transfer in progress and does not start a new one.
- R10: `busy` is 1 from the cycle after an accepted start until the end of the `done` cycle. `done` is 1 for exactly one cycle: the cycle in which `cs_n` has just returned to 1. `rx_word` holds the new value from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle transfer request |
| rate_sel | input | 2 | Bit-rate setting: 0 fast, 1 medium, 2 or 3 slow |
| bit_count | input | 5 | Number of bits to move (clamped to 1..16) |
| tx_word | input | 16 | Output word, right-justified |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, rising edge active |
| cs_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | 16 | Captured input word, right-justified |

## Verification
Two events can land in the same cycle: the completion pulse with its select release, and a fresh start request. The bench drives `start` in exactly the cycle where `done` is high. It judges the result by seeing `busy` low and `cs_n` high on the following cycles, so no second transfer may begin. In the same way, a start with a different output word is injected mid-transfer. The bench confirms at each rising edge that the serial bits still follow the original word. The capture timing is pinned down by a slave model that presents the correct `miso` bit only in the single cycle that R7 names and the inverted bit at all other times.

// File: rtl/scm_pkg.sv
package scm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL,
    ST_FIN
  } scm_state_e;

  // pick one of three values by rate code; codes 2 and 3 share the slow value
  function automatic int unsigned pick_rate(logic [1:0] sel, int unsigned v_fast,
                                            int unsigned v_mid, int unsigned v_slow);
    case (sel)
      2'd0:    return v_fast;
      2'd1:    return v_mid;
      default: return v_slow;
    endcase
  endfunction

  // legal bit count: zero becomes one, above the maximum becomes the maximum
  function automatic int unsigned clamp_bits(int unsigned req, int unsigned nmax);
    if (req == 0) return 1;
    if (req > nmax) return nmax;
    return req;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/scm_timer.sv
module scm_timer #(
  parameter int unsigned CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired,
  output logic [CW-1:0] remain
);
  logic [CW-1:0] cnt_q;

  // a phase loaded with N lasts exactly N cycles: N-1 down to 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val - CW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign expired = (cnt_q == '0);
  assign remain  = cnt_q;
endmodule

// File: rtl/scm_shifter.sv
module scm_shifter #(
  parameter int unsigned NMAX = 16,
  localparam int unsigned NBW = $clog2(NMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NMAX-1:0] tx_word,
  input  logic [NBW-1:0]  nbits,
  input  logic            shift_out,
  input  logic            capture,
  input  logic            miso,
  output logic            mosi,
  output logic [NMAX-1:0] rx_data
);
  logic [NMAX-1:0] tx_sh;
  logic [NMAX-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load)           tx_sh <= tx_word << (NBW'(NMAX) - nbits);
      else if (shift_out) tx_sh <= {tx_sh[NMAX-2:0], 1'b0};
      if (load)           rx_sh <= '0;
      else if (capture)   rx_sh <= {rx_sh[NMAX-2:0], miso};
    end
  end

  assign mosi    = tx_sh[NMAX-1];
  assign rx_data = rx_sh;
endmodule

// File: rtl/serial_cs_master.sv
module serial_cs_master
  import scm_pkg::*;
#(
  parameter int unsigned NMAX        = 16,
  parameter int unsigned T_LOW       = 330,
  parameter int unsigned T_HIGH_FAST = 258,
  parameter int unsigned T_HIGH_MID  = 678,
  parameter int unsigned T_HIGH_SLOW = 9750,
  parameter int unsigned T_SAMP_FAST = 114,
  parameter int unsigned T_SAMP_MID  = 534,
  parameter int unsigned T_SAMP_SLOW = 9606,
  parameter int unsigned T_LEAD      = 912,
  parameter int unsigned T_TRAIL     = 816,
  parameter int unsigned T_SETUP     = 54
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  rate_sel,
  input  logic [4:0]  bit_count,
  input  logic [15:0] tx_word,
  input  logic        miso,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  output logic        busy,
  output logic        done,
  output logic [15:0] rx_word
);
  localparam int unsigned NBW  = $clog2(NMAX + 1);
  localparam int unsigned TMAX = max2(max2(max2(T_LEAD, T_TRAIL), max2(T_LOW, T_HIGH_FAST)),
                                      max2(T_HIGH_MID, T_HIGH_SLOW));
  localparam int unsigned CW   = $clog2(TMAX + 1);

  scm_state_e    state;
  logic          sclk_q, cs_n_q, done_q;
  logic [15:0]   rx_word_q;
  logic [1:0]    rate_q;
  logic [NBW-1:0] bits_left;

  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val, tmr_remain;
  logic [CW-1:0] hi_len, samp_len;
  logic [NBW-1:0] req_bits;
  logic          start_ok, rise_ev, fall_ev, sample_ev, last_bit;
  logic [NMAX-1:0] rx_data;

  assign start_ok  = start && (state == ST_IDLE);
  assign req_bits  = NBW'(clamp_bits(int'(bit_count), NMAX));
  assign hi_len    = CW'(pick_rate(rate_q, T_HIGH_FAST, T_HIGH_MID, T_HIGH_SLOW));
  assign samp_len  = CW'(pick_rate(rate_q, T_SAMP_FAST, T_SAMP_MID, T_SAMP_SLOW));
  assign last_bit  = (bits_left == NBW'(1));
  assign rise_ev   = tmr_expired && (state == ST_LEAD || state == ST_LOW);
  assign fall_ev   = tmr_expired && (state == ST_HIGH);
  // remain counts down from hi_len-1; samp_len cycles after the rising edge
  assign sample_ev = (state == ST_HIGH) && (tmr_remain == hi_len - samp_len);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start_ok) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(T_LEAD);
    end else if (rise_ev) begin
      tmr_load = 1'b1;
      tmr_val  = hi_len;
    end else if (fall_ev) begin
      tmr_load = 1'b1;
      tmr_val  = last_bit ? CW'(T_TRAIL) : CW'(T_LOW);
    end
  end

  scm_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired),
    .remain   (tmr_remain)
  );

  scm_shifter #(.NMAX(NMAX)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .tx_word   (tx_word[NMAX-1:0]),
    .nbits     (req_bits),
    .shift_out (fall_ev && !last_bit),
    .capture   (sample_ev),
    .miso      (miso),
    .mosi      (mosi),
    .rx_data   (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
      rx_word_q <= '0;
      rate_q    <= '0;
      bits_left <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start_ok) begin
          state     <= ST_LEAD;
          cs_n_q    <= 1'b0;
          rate_q    <= rate_sel;
          bits_left <= req_bits;
        end
        ST_LEAD, ST_LOW: if (rise_ev) begin
          state  <= ST_HIGH;
          sclk_q <= 1'b1;
        end
        ST_HIGH: if (fall_ev) begin
          sclk_q <= 1'b0;
          if (last_bit) state <= ST_TRAIL;
          else begin
            state     <= ST_LOW;
            bits_left <= bits_left - NBW'(1);
          end
        end
        ST_TRAIL: if (tmr_expired) begin
          state     <= ST_FIN;
          cs_n_q    <= 1'b1;
          done_q    <= 1'b1;
          rx_word_q <= 16'(rx_data);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk    = sclk_q;
  assign cs_n    = cs_n_q;
  assign done    = done_q;
  assign busy    = (state != ST_IDLE);
  assign rx_word = rx_word_q;
endmodule

// File: rtl/scm_checker.sv
module scm_checker #(
  parameter int unsigned CW      = 14,
  parameter int unsigned T_LEAD  = 912,
  parameter int unsigned T_SETUP = 54
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          cs_n,
  input logic          sclk,
  input logic          mosi,
  input logic          sample_ev,
  input logic [CW-1:0] samp_len
);
  logic [CW:0] hi_cnt, sel_cnt, mosi_age;
  logic        mosi_d, seen_rise;
  localparam logic [CW:0] SAT = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      sel_cnt   <= '0;
      mosi_age  <= SAT;
      mosi_d    <= 1'b0;
      seen_rise <= 1'b0;
    end else begin
      hi_cnt    <= !sclk ? '0 : ((hi_cnt == SAT) ? SAT : hi_cnt + 1'b1);
      sel_cnt   <= cs_n ? '0 : ((sel_cnt == SAT) ? SAT : sel_cnt + 1'b1);
      mosi_d    <= mosi;
      mosi_age  <= (mosi != mosi_d) ? (CW+1)'(1) : ((mosi_age == SAT) ? SAT : mosi_age + 1'b1);
      seen_rise <= cs_n ? 1'b0 : (seen_rise | sclk);
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);  // R2
  AST_LEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !seen_rise) |-> (sel_cnt == (CW+1)'(T_LEAD)));  // R2
  AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (mosi_age >= (CW+1)'(T_SETUP)));  // R6
  AST_SAMPLE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |-> (sclk && hi_cnt == (CW+1)'(samp_len) - 1'b1));  // R7
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(cs_n) && busy));  // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
  AST_LATE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!busy && cs_n));  // R9
endmodule

bind serial_cs_master scm_checker #(
  .CW      (CW),
  .T_LEAD  (T_LEAD),
  .T_SETUP (T_SETUP)
) u_scm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .sample_ev (sample_ev),
  .samp_len  (samp_len)
);

// File: tb/test_serial_cs_master.sv
`timescale 1ns/1ps
module test_serial_cs_master;
  localparam int LOW = 5, LEAD = 8, TRAIL = 6, SETUP = 2;
  localparam int H0 = 3, H1 = 6, H2 = 9;
  localparam int S0 = 2, S1 = 4, S2 = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b1;
  logic [1:0] rate_sel = '0;
  logic [4:0] bit_count = '0;
  logic [15:0] tx_word = '0;
  logic sclk, cs_n, mosi, busy, done;
  logic [15:0] rx_word;

  always #2 clk = ~clk;

  serial_cs_master #(
    .T_LOW(LOW), .T_HIGH_FAST(H0), .T_HIGH_MID(H1), .T_HIGH_SLOW(H2),
    .T_SAMP_FAST(S0), .T_SAMP_MID(S1), .T_SAMP_SLOW(S2),
    .T_LEAD(LEAD), .T_TRAIL(TRAIL), .T_SETUP(SETUP)
  ) i_serial_cs_master (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel),
    .bit_count(bit_count), .tx_word(tx_word), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done),
    .rx_word(rx_word)
  );

  int n_run = 0, n_fail = 0;
  int exp_n = 1, exp_high = H0, exp_samp = S0;
  logic [15:0] exp_tx = '0, exp_sw = '0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // passive monitor plus slave model, all on the falling clock edge
  int t = 0, t_cs = 0, t_rise = 0, t_fall = 0, t_mchg = 0, nrise = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      t++;
      if (mosi != p_mosi) t_mchg = t;
      if (p_cs && !cs_n) begin t_cs = t; nrise = 0; end
      if (cs_n && sclk) chk(1'b0, "R2 clock while deselected", 1, 0);
      if (sclk && !p_sclk) begin
        if (nrise == 0) chk(t - t_cs == LEAD, "R2 lead", t - t_cs, LEAD);
        else            chk(t - t_fall == LOW, "R4 low phase", t - t_fall, LOW);
        if (exp_n - 1 - nrise >= 0)
          chk(mosi == exp_tx[exp_n-1-nrise], "R6 mosi bit", int'(mosi), int'(exp_tx[exp_n-1-nrise]));
        chk(t - t_mchg >= SETUP, "R6 setup", t - t_mchg, SETUP);
        t_rise = t;
        nrise++;
      end
      if (!sclk && p_sclk) begin
        chk(t - t_rise == exp_high, "R3 high phase", t - t_rise, exp_high);
        t_fall = t;
      end
      if (cs_n && !p_cs) begin
        chk(t - t_fall == TRAIL, "R5 trail", t - t_fall, TRAIL);
        chk(nrise == exp_n, "R8 edge count", nrise, exp_n);
        chk(done == 1'b1, "R10 done with release", int'(done), 1);
      end
      // correct bit only in the one cycle that is sampled (R7)
      if (sclk && nrise >= 1 && exp_n - nrise >= 0) begin
        if (t - t_rise == exp_samp - 1) miso <= exp_sw[exp_n-nrise];
        else                            miso <= ~exp_sw[exp_n-nrise];
      end else miso <= 1'b1;
      p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
    end
  end

  task automatic xfer(input int rate, input int req, input logic [15:0] tx,
                      input logic [15:0] sw, input bit poke);
    logic [15:0] mask;
    exp_n    = (req == 0) ? 1 : ((req > 16) ? 16 : req);
    exp_high = (rate == 0) ? H0 : ((rate == 1) ? H1 : H2);
    exp_samp = (rate == 0) ? S0 : ((rate == 1) ? S1 : S2);
    exp_tx = tx; exp_sw = sw;
    mask = (exp_n == 16) ? 16'hFFFF : 16'((32'd1 << exp_n) - 1);
    @(negedge clk);
    start = 1'b1; rate_sel = 2'(rate); bit_count = 5'(req); tx_word = tx;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !cs_n, "R10 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (LEAD + 3) @(negedge clk);
      start = 1'b1; tx_word = ~tx; bit_count = 5'd16; rate_sel = 2'(3 - rate); // R9
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(rx_word == (sw & mask), "R7 captured word", int'(rx_word), int'(sw & mask));
    chk(cs_n == 1'b1, "R10 select released", int'(cs_n), 1);
    if (poke) start = 1'b1;  // coincides with done: must be ignored (R9)
    @(negedge clk);
    start = 1'b0;
    chk(!done && !busy, "R10 done one cycle", int'(done), 0);
    @(negedge clk);
    chk(cs_n && !busy, "R9 no restart", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 reset lines", int'({cs_n, sclk}), 2);
    chk(!busy && !done && rx_word == 16'h0, "R1 reset status", int'(rx_word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int pass = 0; pass < 2; pass++)
      for (int rate = 0; rate < 4; rate++)
        for (int req = 0; req < 18; req++)
          xfer(rate, req, 16'hA5C3 ^ 16'(req * 16'h1111) ^ 16'(pass * 16'h0F0F),
               16'h6D2B ^ 16'(rate * 16'h3C5A) ^ 16'(req * 16'h0707), pass[0]);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule